// File: doc/BRIEF.md
# Token-Counted Sum Reduction Pairing Unit

This block forms the sum of a set of partial values that reach one reduction point as tokens, in any order. Each token carries a data word and a signed count tag. The unit keeps at most one token waiting. When a second token arrives, the unit adds the two data words and adds the two counts. The combined token then goes back into the same unit, where it can pair again. Pairing follows arrival order only, and no operand ordering is imposed, because the sum is commutative.

Completion is found by counting tokens, not by a loop counter. A reduction of n values is launched with one token whose count is n-1 with one sign and n-1 tokens whose counts are 1 with the other sign. After the n-1 pairwise adds, the combined count reaches zero. At that point the unit pulses a done flag for one cycle with the final sum and is empty again. A reduction of a single value is one token with count zero, and that token completes at once.

Top module: `reduce_pair`

## Requirements
- R1: After reset, in_ready_o is 1, done_o is 0 and sum_o is 0.
- R2: A token with a nonzero count that is accepted while the unit is empty is stored. It produces no done_o pulse and no stall.
- R3: A token accepted while another token is stored is paired with it. The data words are added and the counts are added, and the result re-enters the unit one cycle later.
- R4: When a paired result has a count of zero, done_o is 1 for exactly one cycle, with sum_o equal to the total. This is the cycle after the one in which in_ready_o was low for that add.
- R5: A token with count zero that is accepted while the unit is empty completes at once. done_o is 1 in the cycle after acceptance, with sum_o equal to its data.
- R6: in_ready_o is 0 for exactly the one cycle while an add is in flight, and 1 otherwise.
- R7: The final sum does not depend on arrival order. This holds for either sign convention of the counts, one large count of one sign and unit counts of the other.
- R8: Data is DATA_W-bit two's complement and sums wrap modulo 2^DATA_W. For example, 0x7FFFFFFF + 1 gives 0x80000000.
- R9: After done_o the unit is empty, and the next token starts a new reduction unaffected by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Token offered |
| in_ready_o | output | 1 | Token accepted when high with in_valid_i |
| in_data_i | input | DATA_W | Token data word |
| in_cnt_i | input | CNT_W | Token count tag, signed |
| done_o | output | 1 | One-cycle completion pulse |
| sum_o | output | DATA_W | Final sum, valid with done_o, held afterwards |

## Verification
The bench builds the unit with its default widths: 32-bit data and 16-bit counts. These widths make the signed-overflow wrap at 0x7FFFFFFF reachable with two tokens. Counts stay small, so the sign conventions and a single-token reduction can all be tried within a few cycles each. Four-token reductions delivered in different orders cover both the store path and the recirculate path, and the cycle-exact stall and done timing is checked at the ports.

// File: rtl/reduce_pair_pkg.sv
package reduce_pair_pkg;

  typedef enum logic [1:0] {
    ROUTE_IDLE = 2'd0,
    ROUTE_HOLD = 2'd1,
    ROUTE_PAIR = 2'd2,
    ROUTE_DONE = 2'd3
  } route_e;

  // Where the candidate token of this cycle goes
  function automatic route_e pick_route(input logic cand_vld,
                                        input logic cnt_zero,
                                        input logic hold_vld);
    if (!cand_vld)               return ROUTE_IDLE;
    if (hold_vld)                return ROUTE_PAIR;
    if (cnt_zero)                return ROUTE_DONE;
    return ROUTE_HOLD;
  endfunction

endpackage

// File: rtl/reduce_pair_slot.sv
module reduce_pair_slot #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
      cnt_o  <= '0;
    end else if (load_i) begin
      vld_o  <= 1'b1;
      data_o <= data_i;
      cnt_o  <= cnt_i;
    end else if (clear_i) begin
      vld_o  <= 1'b0;
    end
  end

  // R2: a waiting token never carries a finished count
  a_r2_held_cnt_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (cnt_o != '0));

endmodule

// File: rtl/reduce_pair_adder.sv
module reduce_pair_adder #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic [CNT_W-1:0]  a_cnt_i,
  input  logic [DATA_W-1:0] b_data_i,
  input  logic [CNT_W-1:0]  b_cnt_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
      cnt_o  <= '0;
    end else begin
      vld_o <= go_i;
      if (go_i) begin
        data_o <= a_data_i + b_data_i;  // wraps modulo 2^DATA_W
        cnt_o  <= a_cnt_i + b_cnt_i;
      end
    end
  end

  // R6: input stalls during flight, so a result never pairs back to back
  a_r6_single_cycle_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);

endmodule

// File: rtl/reduce_pair.sv
module reduce_pair
  import reduce_pair_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [CNT_W-1:0]  in_cnt_i,
  output logic              done_o,
  output logic [DATA_W-1:0] sum_o
);

  logic              hold_vld;
  logic [DATA_W-1:0] hold_data;
  logic [CNT_W-1:0]  hold_cnt;
  logic              add_vld;
  logic [DATA_W-1:0] add_data;
  logic [CNT_W-1:0]  add_cnt;
  logic              take_ext;
  logic              cand_vld;
  logic [DATA_W-1:0] cand_data;
  logic [CNT_W-1:0]  cand_cnt;
  route_e            route;

  // Stall while an add is in flight; its result owns this cycle
  assign in_ready_o = !add_vld;
  assign take_ext   = in_valid_i && !add_vld;
  assign cand_vld   = add_vld || take_ext;
  assign cand_data  = add_vld ? add_data : in_data_i;
  assign cand_cnt   = add_vld ? add_cnt  : in_cnt_i;

  always_comb route = pick_route(cand_vld, cand_cnt == '0, hold_vld);

  reduce_pair_slot #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (route == ROUTE_HOLD),
    .clear_i (route == ROUTE_PAIR),
    .data_i  (cand_data),
    .cnt_i   (cand_cnt),
    .vld_o   (hold_vld),
    .data_o  (hold_data),
    .cnt_o   (hold_cnt)
  );

  reduce_pair_adder #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_adder (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (route == ROUTE_PAIR),
    .a_data_i (hold_data),
    .a_cnt_i  (hold_cnt),
    .b_data_i (cand_data),
    .b_cnt_i  (cand_cnt),
    .vld_o    (add_vld),
    .data_o   (add_data),
    .cnt_o    (add_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      sum_o  <= '0;
    end else begin
      done_o <= (route == ROUTE_DONE);
      if (route == ROUTE_DONE) sum_o <= cand_data;
    end
  end

  // R4/R9: completion leaves nothing stored and nothing in flight
  a_r9_done_leaves_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!hold_vld && !add_vld));

  // R3: an add starts only against a stored token
  a_r3_pair_needs_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(add_vld) |-> $past(hold_vld));

endmodule

// File: tb/test_reduce_pair.sv
module test_reduce_pair;

  localparam int DW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [CW-1:0] in_cnt = '0;
  logic          in_ready;
  logic          done;
  logic [DW-1:0] sum;

  int n_checks = 0;
  int n_fail   = 0;
  int done_seen = 0;
  logic [DW-1:0] last_sum = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  reduce_pair #(.DATA_W(DW), .CNT_W(CW)) i_reduce_pair (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_cnt_i(in_cnt), .done_o(done), .sum_o(sum)
  );

  always @(negedge clk) if (rst_n && done) begin
    done_seen++;
    last_sum = sum;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Returns at the negedge after the accepting edge
  task automatic send(input logic [DW-1:0] d, input logic [CW-1:0] c);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    in_cnt   = c;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic reduce4(input string req, input logic [DW-1:0] d0, input logic [CW-1:0] c0,
                         input logic [DW-1:0] d1, input logic [CW-1:0] c1,
                         input logic [DW-1:0] d2, input logic [CW-1:0] c2,
                         input logic [DW-1:0] d3, input logic [CW-1:0] c3,
                         input logic [DW-1:0] exp);
    done_seen = 0;
    send(d0, c0);
    send(d1, c1);
    send(d2, c2);
    check({req, " no early done"}, 64'(done_seen), 64'd0);
    send(d3, c3);
    repeat (3) @(negedge clk);
    check({req, " one done"}, 64'(done_seen), 64'd1);
    check({req, " sum"}, 64'(last_sum), 64'(exp));
  endtask

  task automatic t_reset;
    check("R1 ready", 64'(in_ready), 64'd1);
    check("R1 done", 64'(done), 64'd0);
    check("R1 sum", 64'(sum), 64'd0);
  endtask

  task automatic t_store_and_timing;
    // R2: stored token, no stall and no done
    send(32'd10, 16'hFFFF);  // count -1
    check("R2 ready after store", 64'(in_ready), 64'd1);
    check("R2 no done", 64'(done), 64'd0);
    // R3/R6: pairing stalls for one cycle
    send(32'd20, 16'd1);
    check("R6 stall in flight", 64'(in_ready), 64'd0);
    check("R4 not yet done", 64'(done), 64'd0);
    @(negedge clk);
    check("R4 done pulse", 64'(done), 64'd1);
    check("R3 R4 sum", 64'(sum), 64'd30);
    check("R6 ready again", 64'(in_ready), 64'd1);
    @(negedge clk);
    check("R4 pulse one cycle", 64'(done), 64'd0);
    check("R4 sum held", 64'(sum), 64'd30);
  endtask

  task automatic t_single;
    send(32'd99, 16'd0);
    check("R5 immediate done", 64'(done), 64'd1);
    check("R5 sum", 64'(sum), 64'd99);
    check("R5 no stall", 64'(in_ready), 64'd1);
    @(negedge clk);
    check("R5 pulse ends", 64'(done), 64'd0);
  endtask

  task automatic t_orders;
    reduce4("R7 big first", 32'd5, 16'hFFFD, 32'd7, 16'd1, 32'd11, 16'd1, 32'd13, 16'd1, 32'd36);
    reduce4("R7 big last", 32'd13, 16'd1, 32'd11, 16'd1, 32'd7, 16'd1, 32'd5, 16'hFFFD, 32'd36);
    reduce4("R7 big mid", 32'd7, 16'd1, 32'd5, 16'hFFFD, 32'd13, 16'd1, 32'd11, 16'd1, 32'd36);
    reduce4("R7 sign swap", 32'hFFFFFFFB, 16'd3, 32'd2, 16'hFFFF, 32'd4, 16'hFFFF,
            32'd1, 16'hFFFF, 32'd2);
  endtask

  task automatic t_wrap;
    done_seen = 0;
    send(32'h7FFFFFFF, 16'hFFFF);
    send(32'h00000001, 16'd1);
    repeat (3) @(negedge clk);
    check("R8 one done", 64'(done_seen), 64'd1);
    check("R8 wrap sum", 64'(last_sum), 64'h80000000);
  endtask

  task automatic t_fresh;
    // R9: a back-to-back new reduction starts clean
    done_seen = 0;
    send(32'd3, 16'hFFFF);
    send(32'd4, 16'd1);
    send(32'd100, 16'hFFFF);
    send(32'd200, 16'd1);
    repeat (3) @(negedge clk);
    check("R9 two dones", 64'(done_seen), 64'd2);
    check("R9 second sum clean", 64'(last_sum), 64'd300);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_store_and_timing();
    t_single();
    t_orders();
    t_wrap();
    t_fresh();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule